// File: doc/BRIEF.md
# Prioritized Restart Interrupt Vector Unit

This block decides which hardware interrupt a small 8-bit processor core should service next, and what address it should jump to. Five request lines enter it. One is a non-maskable trap. Three are vectored restart lines of high, middle and low rank. The last is a general request line whose target comes from an opcode that outside logic supplies. The request levels are captured on a falling clock edge during the cycle the core marks as the one before its address latch. At the next instruction boundary, the captured requests are filtered by three per-line masks and a global enable. The winner is then reported as a one-cycle acknowledge, together with a source code and a 16-bit vector address.

The vectored lines land on half-step addresses. Each one is four bytes above the restart slot whose number it carries, so the high, middle and low lines go to 003CH, 0034H and 002CH, and the trap goes to 0024H. The high line is edge-sensitive and remembers a rising edge in a pending latch. The middle and low lines, the general line and the trap are all level-sensitive.

A separate opcode port decodes restart instructions, whether they are fetched by software or returned by outside logic after a general request, into their slot address (number times 8). It also flags a call opcode, whose target lies outside this block. The mask port writes the masks and clears the high-line latch. Its read side shows the masks, the enable and the three line states.

Top module: `irq_restart_unit`

## Requirements
- R1: After reset all three masks are set, the global enable is 0, the high-line latch is clear, no acknowledge or opcode result is shown, and `msk_rdata` reads 8'h07.
- R2: A captured trap request is acknowledged with source code 1 and vector 16'h0024, whatever the masks and the global enable, and accepting it leaves the global enable unchanged.
- R3: When several eligible requests are captured together, exactly one is acknowledged, in the order trap, high (code 2), middle (code 3), low (code 4), general (code 5).
- R4: The high, middle and low lines acknowledge with vectors 16'h003C, 16'h0034 and 16'h002C. The general line acknowledges with code 5 and vector 16'h0000, and its target is left to the opcode port.
- R5: A restart line is eligible only when its mask bit is 0 and the global enable is 1. The general line needs only the global enable. Mask bit 0 is the low line, bit 1 the middle line and bit 2 the high line.
- R6: A rising edge on `vreq_hi` sets the high-line latch. The latch clears when a high acknowledge is issued or when a mask write has bit 4 set. A line held high after acknowledge does not request again. `msk_rdata` bit 6 shows the latch.
- R7: The middle and low lines are level-sensitive: a pulse that ends before the capture edge leaves no request behind.
- R8: Acknowledging any request other than the trap clears the global enable in the same edge. `ie_set` and `ie_clr` set and clear it.
- R9: A mask write loads `msk_wdata[2:0]` into the masks only when `msk_wdata[3]` is 1. `msk_rdata` holds the masks in [2:0], the enable in [3], the low and middle line levels in [4] and [5], the high latch in [6], and 0 in [7].
- R10: An opcode of the form 11nnn111 yields `op_is_rst`=1 and vector n*8. The opcode 8'hCD yields `op_is_call`=1 and vector 0. Any other opcode raises neither flag. The result appears one cycle after `op_valid`.
- R11: Requests are captured only on a falling edge while `pre_latch` is high. Arbitration happens only on a rising edge with `insn_end` high, and the acknowledge appears in the cycle after that edge. Each capture serves at most one boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable trap request (level) |
| vreq_hi | input | 1 | High restart line (rising edge latched) |
| vreq_mid | input | 1 | Middle restart line (level) |
| vreq_lo | input | 1 | Low restart line (level) |
| gen_req | input | 1 | General request needing an external opcode (level) |
| pre_latch | input | 1 | Marks the cycle before address latch; capture on its falling edge |
| insn_end | input | 1 | Instruction-boundary strobe |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| msk_wr | input | 1 | Mask write strobe |
| msk_wdata | input | 8 | Mask write data |
| msk_rdata | output | 8 | Mask and status read data |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_src | output | 3 | Source code of acknowledged request |
| ack_vec | output | 16 | Vector address of acknowledged request |
| op_valid | input | 1 | Opcode present |
| op_byte | input | 8 | Opcode to decode |
| op_done | output | 1 | Opcode result valid |
| op_is_rst | output | 1 | Opcode was a restart |
| op_is_call | output | 1 | Opcode was a call |
| op_vec | output | 16 | Decoded restart vector |

## Verification
Several properties are checked on every cycle:
- the grant is one-hot;
- every acknowledge follows a boundary strobe;
- a trap acknowledge always carries 0024H;
- a maskable acknowledge always coincides with a cleared enable and was allowed by the mask and enable of the cycle before;
- mask bits change only on an enabled write;
- the high latch falls only after an acknowledge or a clear request.

Other behaviours can only be shown by the bench's scenarios. These include:
- the actual vectors of each line and the order of priority under mixed requests;
- the absence of a second request from a high line that stays high;
- a level pulse that is lost before capture;
- a capture that is consumed by one boundary;
- the restart and call decoding of every opcode number.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W = 16;
  localparam int OP_W  = 8;
  localparam int NLINE = 5;

  // bit positions in the captured request vector (priority order: high bit wins)
  localparam int B_TRAP = 4;
  localparam int B_HI   = 3;
  localparam int B_MID  = 2;
  localparam int B_LO   = 1;
  localparam int B_GEN  = 0;

  // restart slot numbers used by the half-step lines
  localparam logic [2:0] N_TRAP = 3'd4;
  localparam logic [2:0] N_HI   = 3'd7;
  localparam logic [2:0] N_MID  = 3'd6;
  localparam logic [2:0] N_LO   = 3'd5;

  localparam logic [OP_W-1:0] OP_CALL     = 8'hCD;
  localparam logic [OP_W-1:0] OP_RST_MASK = 8'hC7;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;

  // slot n lives at n*8
  function automatic logic [VEC_W-1:0] slot_addr(input logic [2:0] n);
    return VEC_W'({n, 3'b000});
  endfunction

  // half-step line sits 4 bytes above its slot
  function automatic logic [VEC_W-1:0] half_addr(input logic [2:0] n);
    return slot_addr(n) | VEC_W'(4);
  endfunction

  function automatic logic [VEC_W-1:0] src_addr(input irq_src_e s);
    case (s)
      SRC_TRAP: return half_addr(N_TRAP);
      SRC_HI:   return half_addr(N_HI);
      SRC_MID:  return half_addr(N_MID);
      SRC_LO:   return half_addr(N_LO);
      default:  return '0;
    endcase
  endfunction

  function automatic irq_src_e bit_to_src(input int b);
    case (b)
      B_TRAP:  return SRC_TRAP;
      B_HI:    return SRC_HI;
      B_MID:   return SRC_MID;
      B_LO:    return SRC_LO;
      B_GEN:   return SRC_GEN;
      default: return SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_latch,
  input  logic             nmi_req,
  input  logic             vreq_hi,
  input  logic             vreq_mid,
  input  logic             vreq_lo,
  input  logic             gen_req,
  input  logic             hi_clear,
  output logic             pend_hi,
  output logic [NLINE-1:0] smp,
  output logic             smp_tog
);
  logic prev_hi;
  logic hi_rise;

  assign hi_rise = vreq_hi & ~prev_hi;

  // edge detector and pending latch for the high line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi <= 1'b0;
      pend_hi <= 1'b0;
    end else begin
      prev_hi <= vreq_hi;
      if (hi_clear)     pend_hi <= 1'b0;
      else if (hi_rise) pend_hi <= 1'b1;
    end
  end

  // capture on the falling edge of the cycle before address latch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp     <= '0;
      smp_tog <= 1'b0;
    end else if (pre_latch) begin
      smp[B_TRAP] <= nmi_req;
      smp[B_HI]   <= pend_hi;
      smp[B_MID]  <= vreq_mid;
      smp[B_LO]   <= vreq_lo;
      smp[B_GEN]  <= gen_req;
      smp_tog     <= ~smp_tog;
    end
  end

  // R6
  hi_latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_hi) |-> $past(hi_clear));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NLINE-1:0] smp,
  input  logic [2:0]       mask,
  input  logic             ie,
  output logic [NLINE-1:0] elig,
  output logic [NLINE-1:0] grant,
  output irq_src_e         src
);
  always_comb begin
    elig         = '0;
    elig[B_TRAP] = smp[B_TRAP];
    elig[B_HI]   = smp[B_HI]  & ~mask[2] & ie;
    elig[B_MID]  = smp[B_MID] & ~mask[1] & ie;
    elig[B_LO]   = smp[B_LO]  & ~mask[0] & ie;
    elig[B_GEN]  = smp[B_GEN] & ie;
  end

  // fixed priority: highest index wins
  always_comb begin
    grant = '0;
    src   = SRC_NONE;
    for (int b = 0; b < NLINE; b++) begin
      if (elig[b]) begin
        grant    = '0;
        grant[b] = 1'b1;
        src      = bit_to_src(b);
      end
    end
  end
endmodule

// File: rtl/irq_opdec.sv
module irq_opdec
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_byte,
  output logic             op_done,
  output logic             op_is_rst,
  output logic             op_is_call,
  output logic [VEC_W-1:0] op_vec
);
  logic is_rst_c, is_call_c;

  assign is_rst_c  = (op_byte & OP_RST_MASK) == OP_RST_MASK;
  assign is_call_c = op_byte == OP_CALL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_done    <= 1'b0;
      op_is_rst  <= 1'b0;
      op_is_call <= 1'b0;
      op_vec     <= '0;
    end else begin
      op_done    <= op_valid;
      op_is_rst  <= op_valid & is_rst_c;
      op_is_call <= op_valid & is_call_c;
      op_vec     <= (op_valid & is_rst_c) ? slot_addr(op_byte[5:3]) : '0;
    end
  end

  // R10
  op_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_is_rst || op_is_call) |-> $past(op_valid) && !(op_is_rst && op_is_call));
endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        vreq_hi,
  input  logic        vreq_mid,
  input  logic        vreq_lo,
  input  logic        gen_req,
  input  logic        pre_latch,
  input  logic        insn_end,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        msk_wr,
  input  logic [7:0]  msk_wdata,
  output logic [7:0]  msk_rdata,
  output logic        ack_valid,
  output logic [2:0]  ack_src,
  output logic [15:0] ack_vec,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  output logic        op_done,
  output logic        op_is_rst,
  output logic        op_is_call,
  output logic [15:0] op_vec
);
  localparam int WB_SETEN = 3;
  localparam int WB_HICLR = 4;

  logic [2:0]       mask_q;
  logic             ie_q;
  logic             used_tog;
  logic             pend_hi;
  logic [NLINE-1:0] smp;
  logic             smp_tog;
  logic [NLINE-1:0] elig, grant;
  irq_src_e         win_src;
  logic             fresh, accept, accept_mask, hi_clear;
  irq_src_e         ack_src_q;

  assign fresh       = smp_tog != used_tog;
  assign accept      = insn_end & fresh & (|grant);
  assign accept_mask = accept & ~grant[B_TRAP];
  assign hi_clear    = (accept & grant[B_HI]) | (msk_wr & msk_wdata[WB_HICLR]);

  irq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pre_latch(pre_latch),
    .nmi_req(nmi_req), .vreq_hi(vreq_hi), .vreq_mid(vreq_mid),
    .vreq_lo(vreq_lo), .gen_req(gen_req), .hi_clear(hi_clear),
    .pend_hi(pend_hi), .smp(smp), .smp_tog(smp_tog)
  );

  irq_arbiter u_arb (
    .smp(smp), .mask(mask_q), .ie(ie_q),
    .elig(elig), .grant(grant), .src(win_src)
  );

  irq_opdec u_op (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_done(op_done), .op_is_rst(op_is_rst), .op_is_call(op_is_call),
    .op_vec(op_vec)
  );

  // masks and global enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (msk_wr && msk_wdata[WB_SETEN]) mask_q <= msk_wdata[2:0];
      if (accept_mask)  ie_q <= 1'b0;
      else if (ie_clr)  ie_q <= 1'b0;
      else if (ie_set)  ie_q <= 1'b1;
    end
  end

  // acknowledge and capture consumption
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_tog  <= 1'b0;
      ack_valid <= 1'b0;
      ack_src_q <= SRC_NONE;
      ack_vec   <= '0;
    end else begin
      if (insn_end) used_tog <= smp_tog;
      ack_valid <= accept;
      ack_src_q <= accept ? win_src : SRC_NONE;
      ack_vec   <= accept ? src_addr(win_src) : '0;
    end
  end

  assign ack_src   = ack_src_q;
  assign msk_rdata = {1'b0, pend_hi, vreq_mid, vreq_lo, ie_q, mask_q};

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_src_q == SRC_TRAP) |-> ack_vec == 16'h0024);
  // R8
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_src_q != SRC_TRAP) |-> !ie_q);
  // R11
  ack_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(insn_end));
  // R5
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_src_q == SRC_HI) |-> ($past(ie_q) && !$past(mask_q[2])));
  // R9
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> $past(msk_wr && msk_wdata[WB_SETEN]));
endmodule

// File: tb/sim_irq_restart_unit.sv
module sim_irq_restart_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, vreq_hi = 0, vreq_mid = 0, vreq_lo = 0, gen_req = 0;
  logic pre_latch = 0, insn_end = 0, ie_set = 0, ie_clr = 0, msk_wr = 0;
  logic [7:0]  msk_wdata = 0;
  logic [7:0]  msk_rdata;
  logic        ack_valid;
  logic [2:0]  ack_src;
  logic [15:0] ack_vec;
  logic        op_valid = 0;
  logic [7:0]  op_byte = 0;
  logic        op_done, op_is_rst, op_is_call;
  logic [15:0] op_vec;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_mask = 3'b111;
  logic       m_ie = 1'b0;

  always #4 clk = ~clk;

  irq_restart_unit u0 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .vreq_hi(vreq_hi),
    .vreq_mid(vreq_mid), .vreq_lo(vreq_lo), .gen_req(gen_req),
    .pre_latch(pre_latch), .insn_end(insn_end), .ie_set(ie_set),
    .ie_clr(ie_clr), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .msk_rdata(msk_rdata), .ack_valid(ack_valid), .ack_src(ack_src),
    .ack_vec(ack_vec), .op_valid(op_valid), .op_byte(op_byte),
    .op_done(op_done), .op_is_rst(op_is_rst), .op_is_call(op_is_call),
    .op_vec(op_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected {valid, src, vec}; lv = {trap, hi, mid, lo, gen}
  function automatic logic [19:0] exp_pick(input logic [4:0] lv, input logic [2:0] mk, input logic ie);
    if (lv[4])                  return {1'b1, 3'd1, 16'd36};
    if (ie && lv[3] && !mk[2])  return {1'b1, 3'd2, 16'(7 * 8 + 4)};
    if (ie && lv[2] && !mk[1])  return {1'b1, 3'd3, 16'(6 * 8 + 4)};
    if (ie && lv[1] && !mk[0])  return {1'b1, 3'd4, 16'(5 * 8 + 4)};
    if (ie && lv[0])            return {1'b1, 3'd5, 16'd0};
    return 20'd0;
  endfunction

  // one full request round: optional mask write / enable op, capture, boundary, check
  task automatic step(input string req, input logic [4:0] lv, input logic eff_hi,
                      input logic wr, input logic [4:0] wd, input logic [1:0] ieop,
                      input logic hold);
    logic [19:0] e;
    @(posedge clk); #1;
    msk_wr = wr; msk_wdata = {3'b0, wd}; ie_set = ieop[0]; ie_clr = ieop[1];
    if (!hold) vreq_hi = 1'b0;
    nmi_req = lv[4]; vreq_mid = lv[2]; vreq_lo = lv[1]; gen_req = lv[0];
    @(posedge clk); #1;
    msk_wr = 0; ie_set = 0; ie_clr = 0; vreq_hi = lv[3];
    @(posedge clk); #1; pre_latch = 1;
    @(posedge clk); #1; pre_latch = 0; insn_end = 1;
    @(posedge clk); #1; insn_end = 0;
    if (wr && wd[3]) m_mask = wd[2:0];
    if (ieop[0]) m_ie = 1'b1;
    if (ieop[1]) m_ie = 1'b0;
    e = exp_pick({lv[4], eff_hi, lv[2:0]}, m_mask, m_ie);
    chk({req, " ack_valid"}, 32'(ack_valid), 32'(e[19]));
    chk({req, " ack_src"},   32'(ack_src),   32'(e[18:16]));
    chk({req, " ack_vec"},   32'(ack_vec),   32'(e[15:0]));
    if (e[19] && e[18:16] != 3'd1) m_ie = 1'b0;
    chk({req, " R9 read mask/enable"}, 32'(msk_rdata[3:0]), 32'({m_ie, m_mask}));
    chk({req, " R6 high latch"}, 32'(msk_rdata[6]), 32'(eff_hi && !(e[19] && e[18:16] == 3'd2)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] lv;
    logic [2:0] mk;
    logic       en;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 rdata", 32'(msk_rdata), 32'h07);
    chk("R1 ack", 32'(ack_valid), 0);
    chk("R1 op_done", 32'(op_done), 0);

    // R2 trap with everything masked and disabled
    step("R2 trap", 5'b10000, 0, 0, 5'b0, 2'b00, 0);
    // R9 write without set-enable leaves masks
    step("R9 no-enable write", 5'b00000, 0, 1, 5'b00000, 2'b01, 0);
    // R3 all lines: trap wins, enable kept (R2/R8)
    step("R3 all", 5'b11111, 1, 1, 5'b01000, 2'b00, 0);
    // R4 high, then R8 clears enable
    step("R4 hi", 5'b01111, 1, 0, 5'b0, 2'b00, 0);
    step("R4 mid", 5'b00111, 0, 0, 5'b0, 2'b01, 0);
    step("R4 lo", 5'b00011, 0, 0, 5'b0, 2'b01, 0);
    step("R4 gen", 5'b00001, 0, 0, 5'b0, 2'b01, 0);
    step("R8 enable cleared", 5'b00111, 0, 0, 5'b0, 2'b00, 0);
    // R5 masked high line stays pending
    step("R5 hi masked", 5'b01000, 1, 1, 5'b01100, 2'b01, 0);
    // R6 clear latch by write bit 4, line held high
    step("R6 clear", 5'b01000, 0, 1, 5'b11100, 2'b00, 1);
    // R6 no second request while held high
    step("R6 edge", 5'b01000, 1, 1, 5'b01000, 2'b00, 0);
    step("R6 held", 5'b01000, 0, 0, 5'b0, 2'b01, 1);
    // R5 disabled enable blocks mid/lo
    step("R5 disabled", 5'b00110, 0, 0, 5'b0, 2'b10, 0);

    // R7 lo pulse that ends before capture
    @(posedge clk); #1; ie_set = 1; vreq_lo = 1;
    @(posedge clk); #1; ie_set = 0; vreq_lo = 0; m_ie = 1;
    step("R7 lost pulse", 5'b00000, 0, 0, 5'b0, 2'b00, 0);

    // R11 boundary without a capture, capture without boundary, reuse
    @(posedge clk); #1; nmi_req = 1; insn_end = 1;
    @(posedge clk); #1; insn_end = 0;
    chk("R11 no capture", 32'(ack_valid), 0);
    pre_latch = 1;
    @(posedge clk); #1; pre_latch = 0;
    repeat (2) @(posedge clk);
    #1 chk("R11 no boundary", 32'(ack_valid), 0);
    insn_end = 1;
    @(posedge clk); #1; insn_end = 0;
    chk("R11 late boundary", 32'(ack_src), 1);
    insn_end = 1;
    @(posedge clk); #1; insn_end = 0; nmi_req = 0;
    chk("R11 consumed", 32'(ack_valid), 0);

    // R10 opcode decoding
    for (int n = 0; n < 8; n++) begin
      @(posedge clk); #1; op_valid = 1; op_byte = 8'hC7 | 8'(n << 3);
      @(posedge clk); #1; op_valid = 0;
      chk("R10 rst flag", 32'({op_done, op_is_rst, op_is_call}), 32'b110);
      chk("R10 rst vec", 32'(op_vec), 32'(n * 8));
    end
    @(posedge clk); #1; op_valid = 1; op_byte = 8'hCD;
    @(posedge clk); #1; op_valid = 0;
    chk("R10 call", 32'({op_done, op_is_rst, op_is_call}), 32'b101);
    @(posedge clk); #1; op_valid = 1; op_byte = 8'h3E;
    @(posedge clk); #1; op_valid = 0;
    chk("R10 other", 32'({op_done, op_is_rst, op_is_call}), 32'b100);

    // R3/R5 random mix
    for (int i = 0; i < 150; i++) begin
      lv = 5'($urandom);
      if ($urandom % 3 != 0) lv[4] = 1'b0;
      mk = 3'($urandom);
      en = 1'($urandom);
      step("R3 random", lv, lv[3], 1, {1'b1, 1'($urandom % 4 != 0), mk},
           en ? 2'b01 : 2'b10, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule